// File: doc/BRIEF.md
# Transmit Command and Pause Flow Controller

This block sits on the transmit side of a full-duplex Ethernet MAC. It decides when a frame may be launched, and it keeps track of any pause that the link partner has requested. Software uses two registers. The first is a control and status byte that holds a 2-bit command field, a gate bit for pause-time writes and a read-only busy flag. The second is a 16-bit pause quanta register. That register is copied into outgoing pause frames, and software may change it only while the gate bit is set.

An accepted command starts the frame serializer with a one-cycle start pulse and a frame-kind flag. The busy flag then stays high until the serializer returns done. The serializer reads the pause quanta value from a port that always shows the register.

A received pause loads a down-counter with the quanta from the pause frame. The counter moves down once on each 512-bit-time slot tick. While the counter is non-zero, data-frame starts are held back. Pause-frame sends are never held back. The pause-detect input does not depend on whether receive buffers are available.

Top module: `mac_tx_pause_ctrl`

## Requirements
- R1: After reset, `ctl_rdata` and `ptime_rdata` are 0, `pause_active` is 0 and `ser_start` is 0.
- R2: Writing command code 2'b01 to control bits 1:0 is a data-frame start. If the block is idle and no pause is active, `ser_start` pulses for exactly one cycle on the clock after the write, with `ser_is_pause`=0, and the command field reads 0 from then on.
- R3: Writing command code 2'b10 is a pause send. If the block is idle and `full_duplex`=1, `ser_start` pulses one cycle after the write with `ser_is_pause`=1, and `ser_quanta` equals the pause quanta register.
- R4: A pause command issued while `full_duplex`=0 produces no start pulse, and the command field clears one cycle after the write.
- R5: The busy flag at control bit 7 reads 1 from the cycle in which `ser_start` is high until the clock on which `ser_done` is sampled, and 0 after that. A command-field value written while busy is ignored and the field keeps its value. Bit 7 ignores writes.
- R6: A write to the pause quanta register takes effect only while the gate bit (control bit 4, as last written) is 1. At any other time the value stays unchanged.
- R7: `rx_pause_valid` loads the counter with `rx_pause_quanta`. Each `slot_tick` decrements a non-zero counter. `pause_active` is 1 while the counter is non-zero. A received quanta of 0 ends the pause at once.
- R8: A start command made during an active pause stays pending in the command field and launches one cycle after `pause_active` falls. A pause command still launches while a pause is active.
- R9: Command code 2'b11 is discarded one cycle after the write, with no start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| full_duplex | input | 1 | Link is in full-duplex mode |
| ctl_wr | input | 1 | Write strobe for control byte |
| ctl_wdata | input | 8 | Control write data (bit 4 gate, bits 1:0 command) |
| ctl_rdata | output | 8 | Control read: bit 7 busy, bit 4 gate, bits 1:0 command |
| ptime_wr | input | 1 | Write strobe for pause quanta register |
| ptime_wdata | input | 16 | Pause quanta write data |
| ptime_rdata | output | 16 | Pause quanta register value |
| ser_start | output | 1 | One-cycle launch pulse to the serializer |
| ser_is_pause | output | 1 | Launched frame is a pause frame |
| ser_quanta | output | 16 | Quanta to insert into the outgoing pause frame |
| ser_done | input | 1 | Serializer has finished the frame |
| rx_pause_valid | input | 1 | A pause frame was received |
| rx_pause_quanta | input | 16 | Quanta carried by the received pause frame |
| slot_tick | input | 1 | One pulse per 512 bit times |
| pause_active | output | 1 | A received pause is in effect |

## Verification
The assertions assume that `ser_done` arrives only while the block is busy. They also assume that `rx_pause_valid` and `slot_tick` are single-cycle pulses and that the duplex mode stays fixed while a command is pending. The stimulus keeps to these rules. An automatic serializer responder answers each start pulse with a single done pulse three cycles later. Every other input is driven from tasks between clock edges. The sequences cover gated and ungated quanta writes, all four command codes, writes while busy, and a received pause that is counted down, that is cancelled by a zero quanta, and that is overridden by a pause send.

// File: rtl/mac_tx_pause_ctrl.sv
module mac_tx_pause_ctrl #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full_duplex,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rdata,
  input  logic          ptime_wr,
  input  logic [QW-1:0] ptime_wdata,
  output logic [QW-1:0] ptime_rdata,
  output logic          ser_start,
  output logic          ser_is_pause,
  output logic [QW-1:0] ser_quanta,
  input  logic          ser_done,
  input  logic          rx_pause_valid,
  input  logic [QW-1:0] rx_pause_quanta,
  input  logic          slot_tick,
  output logic          pause_active
);
  localparam logic [1:0] CMD_IDLE  = 2'b00;
  localparam logic [1:0] CMD_START = 2'b01;
  localparam logic [1:0] CMD_PAUSE = 2'b10;

  logic [1:0]    cmd_q;
  logic          busy_q, gate_q;
  logic [QW-1:0] ptime_q, hold_cnt;
  logic          go_data, go_pause, drop_cmd;

  assign pause_active = |hold_cnt;
  assign go_data  = !busy_q && cmd_q == CMD_START && !pause_active;
  assign go_pause = !busy_q && cmd_q == CMD_PAUSE && full_duplex;
  assign drop_cmd = !busy_q && cmd_q != CMD_IDLE && cmd_q != CMD_START;

  assign ctl_rdata   = {busy_q, 2'b00, gate_q, 2'b00, cmd_q};
  assign ptime_rdata = ptime_q;
  assign ser_quanta  = ptime_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q        <= CMD_IDLE;
      busy_q       <= 1'b0;
      gate_q       <= 1'b0;
      ptime_q      <= '0;
      ser_start    <= 1'b0;
      ser_is_pause <= 1'b0;
    end else begin
      ser_start <= go_data || go_pause;
      if (go_data || go_pause) begin
        busy_q       <= 1'b1;
        ser_is_pause <= go_pause;
        cmd_q        <= CMD_IDLE;
      end else if (drop_cmd) begin
        cmd_q <= CMD_IDLE;
      end else if (ctl_wr && !busy_q && cmd_q == CMD_IDLE) begin
        cmd_q <= ctl_wdata[1:0];
      end
      if (busy_q && ser_done) busy_q <= 1'b0;
      if (ctl_wr) gate_q <= ctl_wdata[4];
      if (ptime_wr && gate_q) ptime_q <= ptime_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      hold_cnt <= '0;
    else if (rx_pause_valid)
      hold_cnt <= rx_pause_quanta;
    else if (slot_tick && pause_active)
      hold_cnt <= hold_cnt - 1'b1;
  end
endmodule

module mac_tx_pause_ctrl_chk #(
  parameter int QW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          full_duplex,
  input logic [7:0]    ctl_rdata,
  input logic [QW-1:0] ptime_rdata,
  input logic          ser_start,
  input logic          ser_is_pause,
  input logic          ser_done,
  input logic          pause_active
);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ser_start |=> !ser_start);
  a_r5_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    ser_start |-> ctl_rdata[7]);
  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_done && ctl_rdata[7]) |=> !ctl_rdata[7]);
  a_r4_pause_needs_fd: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_start && ser_is_pause) |-> $past(full_duplex));
  a_r8_no_data_in_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_start && !ser_is_pause) |-> $past(!pause_active));
  a_r6_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ctl_rdata[4]) |-> $stable(ptime_rdata));
endmodule

bind mac_tx_pause_ctrl mac_tx_pause_ctrl_chk #(.QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .ctl_rdata(ctl_rdata),
  .ptime_rdata(ptime_rdata), .ser_start(ser_start), .ser_is_pause(ser_is_pause),
  .ser_done(ser_done), .pause_active(pause_active)
);

// File: tb/mac_tx_pause_ctrl_tb.sv
module mac_tx_pause_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        full_duplex = 1'b1;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_rdata;
  logic        ptime_wr = 1'b0;
  logic [15:0] ptime_wdata = '0;
  logic [15:0] ptime_rdata;
  logic        ser_start, ser_is_pause;
  logic [15:0] ser_quanta;
  logic        ser_done = 1'b0;
  logic        rx_pause_valid = 1'b0;
  logic [15:0] rx_pause_quanta = '0;
  logic        slot_tick = 1'b0;
  logic        pause_active;

  int tests = 0, fails = 0, cyc = 0, dcnt = 0, n_start = 0;
  int m_cmd = 0, m_busy = 0, m_gate = 0, m_ptime = 0, m_cnt = 0, m_start = 0, m_kind = 0;

  always #5 clk = ~clk;

  mac_tx_pause_ctrl u_dut (.*);

  always @(posedge clk) begin
    int n_cmd, n_busy;
    cyc++;
    if (!rst_n) begin
      m_cmd = 0; m_busy = 0; m_gate = 0; m_ptime = 0; m_cnt = 0; m_start = 0; m_kind = 0;
    end else begin
      n_cmd = m_cmd; n_busy = m_busy; m_start = 0;
      if (m_busy != 0 && ser_done) n_busy = 0;
      if (m_busy == 0 && m_cmd != 0) begin
        n_cmd = 0;
        if (m_cmd == 1) begin
          if (m_cnt != 0) n_cmd = 1;
          else begin m_start = 1; m_kind = 0; n_busy = 1; end
        end else if (m_cmd == 2 && full_duplex) begin
          m_start = 1; m_kind = 1; n_busy = 1;
        end
      end else if (ctl_wr && m_busy == 0 && m_cmd == 0) n_cmd = int'(ctl_wdata[1:0]);
      if (ptime_wr && m_gate != 0) m_ptime = int'(ptime_wdata);
      if (ctl_wr) m_gate = int'(ctl_wdata[4]);
      if (rx_pause_valid) m_cnt = int'(rx_pause_quanta);
      else if (slot_tick && m_cnt > 0) m_cnt--;
      m_cmd = n_cmd; m_busy = n_busy;
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("[TB] FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 ctl_rdata", int'(ctl_rdata), 0);
      chk("R1 ptime", int'(ptime_rdata), 0);
      chk("R1 start", int'(ser_start), 0);
      chk("R1 pause_active", int'(pause_active), 0);
    end else begin
      chk("R2 R9 cmd field", int'(ctl_rdata[1:0]), m_cmd);
      chk("R5 busy bit", int'(ctl_rdata[7]), m_busy);
      chk("R6 gate bit", int'(ctl_rdata[4]), m_gate);
      chk("R6 ptime", int'(ptime_rdata), m_ptime);
      chk("R2 R8 start", int'(ser_start), m_start);
      chk("R7 pause_active", int'(pause_active), int'(m_cnt != 0));
      if (m_start != 0) begin
        chk("R3 kind", int'(ser_is_pause), m_kind);
        chk("R3 quanta", int'(ser_quanta), m_ptime);
      end
    end
    ser_done = 1'b0;
    if (ser_start) begin n_start++; dcnt = 3; end
    else if (dcnt > 0) begin dcnt--; if (dcnt == 0) ser_done = 1'b1; end
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic wctl(logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v; @(negedge clk); ctl_wr = 1'b0;
  endtask
  task automatic wpt(logic [15:0] v);
    @(negedge clk); ptime_wr = 1'b1; ptime_wdata = v; @(negedge clk); ptime_wr = 1'b0;
  endtask
  task automatic rxp(logic [15:0] q);
    @(negedge clk); rx_pause_valid = 1'b1; rx_pause_quanta = q; @(negedge clk); rx_pause_valid = 1'b0;
  endtask
  task automatic tick(int n);
    repeat (n) begin @(negedge clk); slot_tick = 1'b1; @(negedge clk); slot_tick = 1'b0; end
  endtask

  initial begin
    fork
      begin : wd
        repeat (5000) @(posedge clk);
        fails++; tests++;
        $display("[TB] FAIL watchdog expired");
      end
      begin
        idle(3); @(negedge clk); rst_n = 1'b1;
        wpt(16'h5555); idle(1);
        chk("R6 ungated write ignored", int'(ptime_rdata), 0);
        wctl(8'h10); wpt(16'h1234); idle(1);
        chk("R6 gated write", int'(ptime_rdata), 16'h1234);
        wctl(8'h11); idle(1);
        wctl(8'h12); idle(8);
        chk("R5 busy ignored write count", n_start, 1);
        wctl(8'h12); idle(8);
        chk("R3 pause launched", n_start, 2);
        full_duplex = 1'b0; wctl(8'h12); idle(4);
        chk("R4 half duplex no launch", n_start, 2);
        full_duplex = 1'b1;
        wctl(8'h13); idle(4);
        chk("R9 code 11 no launch", n_start, 2);
        wctl(8'h00); wpt(16'h7777); idle(1);
        chk("R6 gate cleared", int'(ptime_rdata), 16'h1234);
        rxp(16'd3); wctl(8'h01); idle(3);
        chk("R8 start pending", int'(ctl_rdata[1:0]), 1);
        tick(3); idle(8);
        chk("R8 launched after pause", n_start, 3);
        rxp(16'd5); wctl(8'h02); idle(8);
        chk("R8 pause during pause", n_start, 4);
        wctl(8'h01); idle(2); rxp(16'd0); idle(8);
        chk("R7 zero cancels", n_start, 5);
        idle(4);
        disable wd;
      end
    join
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule